// File: doc/BRIEF.md
# Bitwise Three-Input Truth-Table Unit

This unit evaluates an arbitrary Boolean function of three variables on every bit position of three equal-width operand vectors in parallel. The function is not wired in. An 8-bit immediate supplies it as the output column of a three-input truth table. At each bit position the three operand bits form a 3-bit index into that immediate, and the selected immediate bit becomes the result bit.

The vector is divided into lanes of 32 or 64 bits, chosen on each operation. A per-lane write mask decides which lanes take the computed value. A lane whose mask bit is clear passes operand A through unchanged, so the unit can merge results into an existing value. The result and its valid flag come from one register stage, one clock after the operation is accepted.

Top module: `trilut_unit`

## Requirements
- R1: For each bit position i, the unmasked result bit equals imm[4*A[i] + 2*B[i] + C[i]]. Operand A is the most significant index bit and C the least significant.
- R2: Named constants give the expected functions. 0xCA gives A ? B : C. 0x96 gives A^B^C. 0xE8 gives the majority of the three bits. 0xFE gives A|B|C. 0x80 gives A&B&C. 0xA2 gives (A | ~B) & C.
- R3: With the variables applied in reverse (third variable on op_a, first on op_c), 0x16 is true when exactly one input is set and 0x68 when exactly two are set.
- R4: When lane_mode is 0 (32-bit lanes), mask bit k governs result bits 32k to 32k+31.
- R5: When lane_mode is 1 (64-bit lanes), mask bit k governs result bits 64k to 64k+63, and mask bits at or above VEC_W/64 have no effect.
- R6: In a lane whose mask bit is 0 the result equals op_a, and an all-ones mask gives the unmasked function everywhere.
- R7: out_valid equals in_valid delayed by one clock, and out_result shows the operation accepted on the previous edge.
- R8: While in_valid is low, out_result keeps its value whatever the other inputs do.
- R9: Synchronous active-low reset clears out_valid and out_result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept the operation on this edge |
| op_a | input | VEC_W | Operand A (most significant index bit, merge source) |
| op_b | input | VEC_W | Operand B (middle index bit) |
| op_c | input | VEC_W | Operand C (least significant index bit) |
| imm | input | 8 | Truth-table result column, bit n is the output for index n |
| lane_mode | input | 1 | 0: 32-bit lanes, 1: 64-bit lanes |
| lane_mask | input | VEC_W/32 | Per-lane write enable |
| out_valid | output | 1 | Result valid |
| out_result | output | VEC_W | Registered result |

## Verification
The bench builds the unit with VEC_W = 128, which gives four narrow lanes and two wide lanes. With that width every lane boundary, and the unused upper mask bits in wide mode, is reached with few random words. Under this parameter every one of the 256 immediates runs in both lane modes against a bench model. Mixed masks show that lane granularity follows lane_mode, and directed cases pin the named constants and the hold behaviour.

// File: rtl/trilut_pkg.sv
// Shared definitions for the truth-table unit.
// Assumes lane widths are fixed at 32 and 64 bits.
package trilut_pkg;
    typedef enum logic {
        LANE_NARROW = 1'b0,
        LANE_WIDE   = 1'b1
    } lane_mode_e;

    localparam int NARROW_BITS = 32;
    localparam int WIDE_BITS   = 64;
    localparam int IMM_BITS    = 8;
endpackage

// File: rtl/trilut_bitslice.sv
// Per-bit evaluator: each bit triple indexes the immediate.
// Assumes all operands have the same width W.
module trilut_bitslice #(
    parameter int W = 512
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic [7:0]   imm,
    output logic [W-1:0] f
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Select the table entry for this position's index {a,b,c}.
        assign f[i] = imm[{a[i], b[i], c[i]}];
    end
endmodule

// File: rtl/trilut_lane_mask.sv
// Expands the per-lane mask into a per-bit enable for the chosen lane size.
// Assumes W is a multiple of 64; the mask has one bit per 32-bit lane.
module trilut_lane_mask
    import trilut_pkg::*;
#(
    parameter int W = 512,
    localparam int MW = W / NARROW_BITS
) (
    input  lane_mode_e    mode,
    input  logic [MW-1:0] mask,
    output logic [W-1:0]  bit_en
);
    for (genvar i = 0; i < W; i++) begin : g_en
        // Pick the governing mask bit for this position by lane granularity.
        assign bit_en[i] = (mode == LANE_WIDE) ? mask[i / WIDE_BITS]
                                               : mask[i / NARROW_BITS];
    end
endmodule

// File: rtl/trilut_out_stage.sv
// Single register stage holding result and valid flag.
// Assumes synchronous active-low reset; data loads only on load.
module trilut_out_stage #(
    parameter int W = 512
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic         q_valid,
    output logic [W-1:0] q
);
    // Register the valid strobe and capture data on accepted operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q       <= '0;
        end else begin
            q_valid <= load;
            if (load) q <= d;
        end
    end
endmodule

// File: rtl/trilut_unit.sv
// Top: three-input truth-table evaluation over a vector, lane-masked merge
// with op_a, one pipeline register. Assumes VEC_W is a multiple of 64.
module trilut_unit
    import trilut_pkg::*;
#(
    parameter int VEC_W = 512
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [VEC_W-1:0]      op_a,
    input  logic [VEC_W-1:0]      op_b,
    input  logic [VEC_W-1:0]      op_c,
    input  logic [7:0]            imm,
    input  logic                  lane_mode,
    input  logic [VEC_W/32-1:0]   lane_mask,
    output logic                  out_valid,
    output logic [VEC_W-1:0]      out_result
);
    localparam int MASK_W = VEC_W / NARROW_BITS;

    if (VEC_W % WIDE_BITS != 0) begin : g_bad_width
        $error("VEC_W must be a multiple of 64");
    end

    logic [VEC_W-1:0] func_bits;
    logic [VEC_W-1:0] bit_en;
    logic [VEC_W-1:0] merged;
    lane_mode_e       mode_q;

    assign mode_q = lane_mode_e'(lane_mode);

    trilut_bitslice #(.W(VEC_W)) u_eval (
        .a(op_a), .b(op_b), .c(op_c), .imm(imm), .f(func_bits)
    );

    trilut_lane_mask #(.W(VEC_W)) u_mask (
        .mode(mode_q), .mask(lane_mask[MASK_W-1:0]), .bit_en(bit_en)
    );

    // Merge: enabled bits take the function, others keep operand A.
    always_comb begin
        merged = (func_bits & bit_en) | (op_a & ~bit_en);
    end

    trilut_out_stage #(.W(VEC_W)) u_out (
        .clk(clk), .rst_n(rst_n), .load(in_valid), .d(merged),
        .q_valid(out_valid), .q(out_result)
    );
endmodule

// File: rtl/trilut_unit_chk.sv
// Checker for trilut_unit: timing, hold, reset and a few port-level
// functional identities. Bound to every trilut_unit instance.
module trilut_unit_chk #(
    parameter int VEC_W = 512
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [VEC_W-1:0]    op_a,
    input logic [7:0]          imm,
    input logic [VEC_W/32-1:0] lane_mask,
    input logic                out_valid,
    input logic [VEC_W-1:0]    out_result
);
    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));
    assert_reset_clears_R9: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_result == '0));
    assert_zero_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_mask == '0) |=> out_result == $past(op_a));
    assert_const_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && imm == 8'h00 && &lane_mask) |=> out_result == '0);
    assert_const_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && imm == 8'hFF && &lane_mask) |=> &out_result);
    assert_pass_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && imm == 8'hF0) |=> out_result == $past(op_a));
endmodule

bind trilut_unit trilut_unit_chk #(.VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a),
    .imm(imm), .lane_mask(lane_mask), .out_valid(out_valid),
    .out_result(out_result)
);

// File: tb/trilut_unit_tb.sv
module trilut_unit_tb;
    localparam int W  = 128;
    localparam int MW = W / 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  op_a = '0, op_b = '0, op_c = '0;
    logic [7:0]    imm = 8'h00;
    logic          lane_mode = 1'b0;
    logic [MW-1:0] lane_mask = '0;
    logic          out_valid;
    logic [W-1:0]  out_result;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    trilut_unit #(.VEC_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a),
        .op_b(op_b), .op_c(op_c), .imm(imm), .lane_mode(lane_mode),
        .lane_mask(lane_mask), .out_valid(out_valid), .out_result(out_result)
    );

    always #5 clk = ~clk;

    function automatic logic [W-1:0] rnd_vec();
        logic [W-1:0] v;
        for (int k = 0; k < W / 32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    // Model from R1, R4, R5, R6.
    function automatic logic [W-1:0] model(logic [W-1:0] a, logic [W-1:0] b,
            logic [W-1:0] c, logic [7:0] t, logic wide, logic [MW-1:0] m);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            int idx;
            int lane;
            idx  = 4 * int'(a[i]) + 2 * int'(b[i]) + int'(c[i]);
            lane = wide ? i / 64 : i / 32;
            r[i] = m[lane] ? t[idx] : a[i];
        end
        return r;
    endfunction

    task automatic check_vec(string tag, logic [W-1:0] got, logic [W-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic check_bit(string tag, logic got, logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    // Drive one operation at a falling edge; result is checked one cycle later.
    task automatic run_op(string tag, logic [W-1:0] a, logic [W-1:0] b,
            logic [W-1:0] c, logic [7:0] t, logic wide, logic [MW-1:0] m,
            logic [W-1:0] exp);
        @(negedge clk);
        op_a = a; op_b = b; op_c = c; imm = t; lane_mode = wide;
        lane_mask = m; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit({tag, " valid R7"}, out_valid, 1'b1);
        check_vec(tag, out_result, exp);
    endtask

    initial begin
        logic [W-1:0] a, b, c, e;
        void'($urandom(32'hC0FFEE));

        // R9: reset state.
        repeat (3) @(negedge clk);
        check_bit("R9 reset valid", out_valid, 1'b0);
        check_vec("R9 reset result", out_result, '0);
        rst_n = 1'b1;

        // R2: named constants against explicit expressions.
        a = rnd_vec(); b = rnd_vec(); c = rnd_vec();
        run_op("R2 0xCA select", a, b, c, 8'hCA, 1'b0, '1, (a & b) | (~a & c));
        run_op("R2 0x96 xor", a, b, c, 8'h96, 1'b1, '1, a ^ b ^ c);
        run_op("R2 0xE8 majority", a, b, c, 8'hE8, 1'b0, '1, (a & b) | (a & c) | (b & c));
        run_op("R2 0xFE or", a, b, c, 8'hFE, 1'b1, '1, a | b | c);
        run_op("R2 0x80 and", a, b, c, 8'h80, 1'b0, '1, a & b & c);
        run_op("R2 0xA2", a, b, c, 8'hA2, 1'b0, '1, (a | ~b) & c);

        // R3: reversed operand order; x on op_c, y on op_b, z on op_a.
        run_op("R3 0x16 exactly one", c, b, a, 8'h16, 1'b0, '1,
               (a ^ b ^ c) & ~(a & b & c));
        run_op("R3 0x68 exactly two", c, b, a, 8'h68, 1'b1, '1,
               ((a & b) | (a & c) | (b & c)) & ~(a & b & c));

        // R4: narrow lanes, mask 0101 -> bits 0-31 and 64-95 computed.
        e = {a[127:96], ~a[95:64] , a[63:32], ~a[31:0]};
        run_op("R4 narrow mask", a, b, c, 8'h0F, 1'b0, 4'b0101, e);
        // R5: wide lanes, mask 0101 -> lane 0 only; upper mask bit ignored.
        e = {a[127:64], ~a[63:0]};
        run_op("R5 wide mask", a, b, c, 8'h0F, 1'b1, 4'b0101, e);
        run_op("R5 wide upper bits ignored", a, b, c, 8'h0F, 1'b1, 4'b1100, a);
        // R6: zero mask merges op_a.
        run_op("R6 zero mask", a, b, c, 8'h3C, 1'b0, 4'b0000, a);

        // R8: hold with in_valid low while inputs change.
        e = out_result;
        @(negedge clk);
        op_a = rnd_vec(); op_b = rnd_vec(); imm = 8'h55; lane_mask = '1;
        @(negedge clk);
        check_vec("R8 hold", out_result, e);
        check_bit("R7 idle valid", out_valid, 1'b0);

        // R1 with R4/R5/R6: all immediates in both modes.
        for (int t = 0; t < 256; t++) begin
            for (int md = 0; md < 2; md++) begin
                logic [MW-1:0] m;
                a = rnd_vec(); b = rnd_vec(); c = rnd_vec();
                m = (t % 4 == 0) ? MW'($urandom) : '1;
                run_op($sformatf("R1 imm=%02h mode=%0d", t, md), a, b, c,
                       8'(t), 1'(md), m, model(a, b, c, 8'(t), 1'(md), m));
            end
        end

        // R9: reset in the middle of operation.
        @(negedge clk);
        in_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit("R9 mid reset valid", out_valid, 1'b0);
        check_vec("R9 mid reset result", out_result, '0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog got=timeout exp=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule